// File: doc/BRIEF.md
# Multi-SIMD Wavefront Issue Scheduler

This block chooses, on every clock, which resident wavefront gets to issue its next instruction. It serves several SIMD vector units, each with a fixed number of wavefront slots. Every slot records whether it holds a wavefront, whether that wavefront is stalled on a memory result, and the wavefront's program counter. A wavefront is placed on one unit when it is allocated and stays there until it is released.

The scheduler visits one unit per cycle in a fixed rotation. On the visited unit it looks past wavefronts that are waiting on memory and takes the next ready one after the slot that issued last. This hides memory latency by switching wavefronts instead of stalling. A grant reports the unit, the slot and that slot's program counter. One issue keeps its unit occupied for four cycles, so the unit is not granted again inside that window. A separate write port lets the pipeline store an advanced program counter back into a slot.

Top module: `wf_issue_sched`

## Requirements
- R1: Starting with unit 0 in the first cycle after reset, the scheduler visits units 0,1,2,3,0,... advancing one unit per cycle. A grant (`issue_valid`=1) only names the unit visited in that cycle, so there is at most one grant per cycle and two consecutive grants never name the same unit.
- R2: `alloc_ok` is 1 exactly when `alloc_valid` is 1 and the target unit has a free slot. `alloc_slot` gives the lowest-numbered free slot of the target unit, or 0 when the unit is full. An accepted allocation makes that slot valid and ready, with PC = `alloc_pc`, from the next cycle. A request to a unit that already holds 10 wavefronts is refused.
- R3: A unit that received a grant gets no further grant for the next 3 cycles (one issue lasts 4 cycles). A unit whose `simd_busy` bit is 1 in the cycle it is visited gets no grant in that cycle.
- R4: On the visited unit the grant goes to the first valid, non-waiting slot found by searching upward from the slot after the one that issued last, wrapping from slot 9 to slot 0. After reset the search starts at slot 0.
- R5: `issue_pc` equals the stored PC of the granted slot. A PC write (`pcw_valid`) replaces that slot's PC from the next cycle.
- R6: A memory-wait set for a slot removes that slot from selection from the next cycle on. A wait-complete clears the flag, and the slot can be selected again from the following cycle. When set and clear target the same slot in the same cycle, the set wins.
- R7: A release makes the slot invalid from the next cycle. The slot can then be allocated again and is reported by `alloc_slot` as free.
- R8: When the visited unit has no valid, ready slot, `issue_valid` is 0 and `issue_simd`, `issue_slot` and `issue_pc` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| alloc_valid | input | 1 | Request to place a new wavefront |
| alloc_simd | input | 2 | Unit the new wavefront is bound to |
| alloc_pc | input | 48 | Starting program counter |
| alloc_ok | output | 1 | Allocation accepted this cycle |
| alloc_slot | output | 4 | Lowest free slot of the target unit |
| rel_valid | input | 1 | Release a wavefront |
| rel_simd | input | 2 | Unit of the released slot |
| rel_slot | input | 4 | Released slot |
| wset_valid | input | 1 | Mark a slot as waiting on memory |
| wset_simd | input | 2 | Unit of the waiting slot |
| wset_slot | input | 4 | Waiting slot |
| wclr_valid | input | 1 | Memory result returned for a slot |
| wclr_simd | input | 2 | Unit of the completed slot |
| wclr_slot | input | 4 | Completed slot |
| pcw_valid | input | 1 | Store an advanced PC |
| pcw_simd | input | 2 | Unit of the PC write |
| pcw_slot | input | 4 | Slot of the PC write |
| pcw_pc | input | 48 | New program counter |
| simd_busy | input | 4 | Per-unit external hold, one bit per unit |
| issue_valid | output | 1 | Grant this cycle |
| issue_simd | output | 2 | Granted unit |
| issue_slot | output | 4 | Granted slot |
| issue_pc | output | 48 | PC of the granted slot |

## Verification
The assertions assume that slot indices on every command port are below 10, and that a release, wait or PC write never targets, in the same cycle, the slot an accepted allocation is filling. The stimulus follows both rules: it uses only in-range slot numbers and issues one command per cycle. It drives `simd_busy` freely, because the block must tolerate any pattern there. A reference model in the bench, built from the requirements, predicts every output in every cycle. Windowed grant counts confirm fairness, wait skipping and idle units.

// File: rtl/wf_sched_pkg.sv
// Package: default sizing shared by the wavefront issue scheduler and its bench.
// Assumes: consumers derive index widths from these values.
package wf_sched_pkg;
    localparam int DEF_NUM_SIMD     = 4;
    localparam int DEF_NUM_SLOTS    = 10;
    localparam int DEF_PC_W         = 48;
    localparam int DEF_ISSUE_CYCLES = 4;
endpackage

// File: rtl/wf_rr_pick.sv
// Module: rotating-priority picker. Returns the first set request found by
// searching upward from the index after `last`, wrapping at N.
// Assumes: last < N. With last = N-1 it returns the lowest set index.
module wf_rr_pick #(
    parameter int N  = 10,
    parameter int IW = 4
) (
    input  logic [N-1:0]  req,
    input  logic [IW-1:0] last,
    output logic          hit,
    output logic [IW-1:0] idx
);
    // Walk the requests in rotated order and keep the first one found.
    always_comb begin
        hit = 1'b0;
        idx = '0;
        for (int k = 1; k <= N; k++) begin
            int j;
            j = (int'(last) + k) % N;
            if (!hit && req[j]) begin
                hit = 1'b1;
                idx = IW'(j);
            end
        end
    end
endmodule

// File: rtl/wf_slot_bank.sv
// Module: wavefront slot storage for one SIMD unit plus its ready picker.
// Holds valid, waiting and PC per slot and remembers the last issued slot.
// Assumes: slot indices are in range, and no other command targets the slot
// being allocated in the same cycle.
module wf_slot_bank #(
    parameter int NUM_SLOTS = 10,
    parameter int SLOT_W    = 4,
    parameter int PC_W      = 48
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              alloc_en,
    input  logic [PC_W-1:0]   alloc_pc,
    output logic              free_any,
    output logic [SLOT_W-1:0] free_slot,
    input  logic              rel_en,
    input  logic [SLOT_W-1:0] rel_slot,
    input  logic              wset_en,
    input  logic [SLOT_W-1:0] wset_slot,
    input  logic              wclr_en,
    input  logic [SLOT_W-1:0] wclr_slot,
    input  logic              pcw_en,
    input  logic [SLOT_W-1:0] pcw_slot,
    input  logic [PC_W-1:0]   pcw_val,
    input  logic              grant,
    output logic              pick_valid,
    output logic [SLOT_W-1:0] pick_slot,
    output logic [PC_W-1:0]   pick_pc
);
    localparam logic [SLOT_W-1:0] TOP_SLOT = SLOT_W'(NUM_SLOTS - 1);

    logic [NUM_SLOTS-1:0] valid_q;
    logic [NUM_SLOTS-1:0] wait_q;
    logic [NUM_SLOTS-1:0] ready;
    logic [PC_W-1:0]      pc_q [NUM_SLOTS];
    logic [SLOT_W-1:0]    last_q;
    logic                 take;

    assign ready = valid_q & ~wait_q;
    assign take  = alloc_en && free_any;

    // Lowest free slot: a rotating search that starts right after the top slot.
    wf_rr_pick #(.N(NUM_SLOTS), .IW(SLOT_W)) u_free (
        .req (~valid_q),
        .last(TOP_SLOT),
        .hit (free_any),
        .idx (free_slot)
    );

    // Next ready wavefront after the one that issued last.
    wf_rr_pick #(.N(NUM_SLOTS), .IW(SLOT_W)) u_ready (
        .req (ready),
        .last(last_q),
        .hit (pick_valid),
        .idx (pick_slot)
    );

    // Read the PC of the picked slot.
    always_comb begin
        pick_pc = '0;
        for (int i = 0; i < NUM_SLOTS; i++)
            if (pick_slot == SLOT_W'(i)) pick_pc = pc_q[i];
    end

    // Per-slot state update: allocation first, then release, wait and PC write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= '0;
            wait_q  <= '0;
            for (int i = 0; i < NUM_SLOTS; i++) pc_q[i] <= '0;
        end else begin
            for (int i = 0; i < NUM_SLOTS; i++) begin
                if (take && free_slot == SLOT_W'(i)) begin
                    valid_q[i] <= 1'b1;
                    wait_q[i]  <= 1'b0;
                    pc_q[i]    <= alloc_pc;
                end else begin
                    if (rel_en && rel_slot == SLOT_W'(i)) valid_q[i] <= 1'b0;
                    if (wset_en && wset_slot == SLOT_W'(i))      wait_q[i] <= 1'b1;
                    else if (wclr_en && wclr_slot == SLOT_W'(i)) wait_q[i] <= 1'b0;
                    if (pcw_en && pcw_slot == SLOT_W'(i)) pc_q[i] <= pcw_val;
                end
            end
        end
    end

    // Remember the slot that issued so the next search starts after it.
    always_ff @(posedge clk) begin
        if (!rst_n)     last_q <= TOP_SLOT;
        else if (grant) last_q <= pick_slot;
    end

    // R2
    alloc_into_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
        take |-> !valid_q[free_slot]);
    // R2
    full_refuse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (&valid_q) |-> !free_any);
    // R6
    pick_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pick_valid |-> (valid_q[pick_slot] && !wait_q[pick_slot]));
    // R6
    wait_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wset_en && !take) |=> !(pick_valid && pick_slot == $past(wset_slot)));
endmodule

// File: rtl/wf_issue_sched.sv
// Module: top of the wavefront issue scheduler. Rotates over the SIMD units
// one per cycle, holds each unit for ISSUE_CYCLES after a grant, and routes
// slot commands to the per-unit banks.
// Assumes: command slot indices are below NUM_SLOTS; NUM_SIMD > 1.
module wf_issue_sched
    import wf_sched_pkg::*;
#(
    parameter int NUM_SIMD     = DEF_NUM_SIMD,
    parameter int NUM_SLOTS    = DEF_NUM_SLOTS,
    parameter int PC_W         = DEF_PC_W,
    parameter int ISSUE_CYCLES = DEF_ISSUE_CYCLES,
    localparam int SIMD_W = (NUM_SIMD > 1) ? $clog2(NUM_SIMD) : 1,
    localparam int SLOT_W = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              alloc_valid,
    input  logic [SIMD_W-1:0] alloc_simd,
    input  logic [PC_W-1:0]   alloc_pc,
    output logic              alloc_ok,
    output logic [SLOT_W-1:0] alloc_slot,
    input  logic              rel_valid,
    input  logic [SIMD_W-1:0] rel_simd,
    input  logic [SLOT_W-1:0] rel_slot,
    input  logic              wset_valid,
    input  logic [SIMD_W-1:0] wset_simd,
    input  logic [SLOT_W-1:0] wset_slot,
    input  logic              wclr_valid,
    input  logic [SIMD_W-1:0] wclr_simd,
    input  logic [SLOT_W-1:0] wclr_slot,
    input  logic              pcw_valid,
    input  logic [SIMD_W-1:0] pcw_simd,
    input  logic [SLOT_W-1:0] pcw_slot,
    input  logic [PC_W-1:0]   pcw_pc,
    input  logic [NUM_SIMD-1:0] simd_busy,
    output logic              issue_valid,
    output logic [SIMD_W-1:0] issue_simd,
    output logic [SLOT_W-1:0] issue_slot,
    output logic [PC_W-1:0]   issue_pc
);
    localparam int CNT_W = (ISSUE_CYCLES > 2) ? $clog2(ISSUE_CYCLES) : 1;
    localparam logic [CNT_W-1:0] HOLD = CNT_W'(ISSUE_CYCLES - 1);
    localparam logic [SIMD_W-1:0] LAST_SIMD = SIMD_W'(NUM_SIMD - 1);

    logic [SIMD_W-1:0] ptr_q;
    logic [CNT_W-1:0]  occ_q [NUM_SIMD];

    logic [NUM_SIMD-1:0] bank_free_any;
    logic [SLOT_W-1:0]   bank_free_slot [NUM_SIMD];
    logic [NUM_SIMD-1:0] bank_pick_valid;
    logic [SLOT_W-1:0]   bank_pick_slot [NUM_SIMD];
    logic [PC_W-1:0]     bank_pick_pc   [NUM_SIMD];

    logic              sel_ok;
    logic [SLOT_W-1:0] sel_slot;
    logic [PC_W-1:0]   sel_pc;

    // One slot bank per SIMD unit, each seeing only commands addressed to it.
    for (genvar b = 0; b < NUM_SIMD; b++) begin : g_bank
        wf_slot_bank #(.NUM_SLOTS(NUM_SLOTS), .SLOT_W(SLOT_W), .PC_W(PC_W)) u_bank (
            .clk       (clk),
            .rst_n     (rst_n),
            .alloc_en  (alloc_valid && alloc_simd == SIMD_W'(b)),
            .alloc_pc  (alloc_pc),
            .free_any  (bank_free_any[b]),
            .free_slot (bank_free_slot[b]),
            .rel_en    (rel_valid && rel_simd == SIMD_W'(b)),
            .rel_slot  (rel_slot),
            .wset_en   (wset_valid && wset_simd == SIMD_W'(b)),
            .wset_slot (wset_slot),
            .wclr_en   (wclr_valid && wclr_simd == SIMD_W'(b)),
            .wclr_slot (wclr_slot),
            .pcw_en    (pcw_valid && pcw_simd == SIMD_W'(b)),
            .pcw_slot  (pcw_slot),
            .pcw_val   (pcw_pc),
            .grant     (issue_valid && ptr_q == SIMD_W'(b)),
            .pick_valid(bank_pick_valid[b]),
            .pick_slot (bank_pick_slot[b]),
            .pick_pc   (bank_pick_pc[b])
        );
    end

    // Report free-slot status of the unit an allocation targets.
    always_comb begin
        alloc_ok   = 1'b0;
        alloc_slot = '0;
        for (int b = 0; b < NUM_SIMD; b++) begin
            if (alloc_simd == SIMD_W'(b)) begin
                alloc_ok   = alloc_valid && bank_free_any[b];
                alloc_slot = bank_free_slot[b];
            end
        end
    end

    // Select the visited unit and decide whether it may issue this cycle.
    always_comb begin
        sel_ok   = 1'b0;
        sel_slot = '0;
        sel_pc   = '0;
        for (int b = 0; b < NUM_SIMD; b++) begin
            if (ptr_q == SIMD_W'(b)) begin
                sel_ok   = bank_pick_valid[b] && occ_q[b] == '0 && !simd_busy[b];
                sel_slot = bank_pick_slot[b];
                sel_pc   = bank_pick_pc[b];
            end
        end
        issue_valid = sel_ok;
        issue_simd  = sel_ok ? ptr_q    : '0;
        issue_slot  = sel_ok ? sel_slot : '0;
        issue_pc    = sel_ok ? sel_pc   : '0;
    end

    // Advance the unit rotation by one every cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)                  ptr_q <= '0;
        else if (ptr_q == LAST_SIMD) ptr_q <= '0;
        else                         ptr_q <= ptr_q + 1'b1;
    end

    // Count down the remaining cycles of each unit's current issue.
    always_ff @(posedge clk) begin
        for (int b = 0; b < NUM_SIMD; b++) begin
            if (!rst_n)                                     occ_q[b] <= '0;
            else if (issue_valid && ptr_q == SIMD_W'(b))    occ_q[b] <= HOLD;
            else if (occ_q[b] != '0)                        occ_q[b] <= occ_q[b] - 1'b1;
        end
    end

    // R1
    rotate_unit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        issue_valid |=> (!issue_valid || issue_simd != $past(issue_simd)));
    // R3
    busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        issue_valid |-> !simd_busy[issue_simd]);
    // R8
    idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !issue_valid |-> (issue_slot == '0 && issue_pc == '0));
endmodule

// File: tb/tb_wf_issue_sched.sv
`timescale 1ns/1ps
module tb_wf_issue_sched;
    localparam int NS = 4;
    localparam int NW = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        alloc_valid = 0; logic [1:0] alloc_simd = 0; logic [47:0] alloc_pc = 0;
    logic        alloc_ok;        logic [3:0] alloc_slot;
    logic        rel_valid = 0;   logic [1:0] rel_simd = 0;   logic [3:0] rel_slot = 0;
    logic        wset_valid = 0;  logic [1:0] wset_simd = 0;  logic [3:0] wset_slot = 0;
    logic        wclr_valid = 0;  logic [1:0] wclr_simd = 0;  logic [3:0] wclr_slot = 0;
    logic        pcw_valid = 0;   logic [1:0] pcw_simd = 0;   logic [3:0] pcw_slot = 0;
    logic [47:0] pcw_pc = 0;
    logic [3:0]  simd_busy = 0;
    logic        issue_valid;     logic [1:0] issue_simd;     logic [3:0] issue_slot;
    logic [47:0] issue_pc;

    always #2 clk = ~clk;

    wf_issue_sched dut (
        .clk(clk), .rst_n(rst_n),
        .alloc_valid(alloc_valid), .alloc_simd(alloc_simd), .alloc_pc(alloc_pc),
        .alloc_ok(alloc_ok), .alloc_slot(alloc_slot),
        .rel_valid(rel_valid), .rel_simd(rel_simd), .rel_slot(rel_slot),
        .wset_valid(wset_valid), .wset_simd(wset_simd), .wset_slot(wset_slot),
        .wclr_valid(wclr_valid), .wclr_simd(wclr_simd), .wclr_slot(wclr_slot),
        .pcw_valid(pcw_valid), .pcw_simd(pcw_simd), .pcw_slot(pcw_slot), .pcw_pc(pcw_pc),
        .simd_busy(simd_busy),
        .issue_valid(issue_valid), .issue_simd(issue_simd),
        .issue_slot(issue_slot), .issue_pc(issue_pc)
    );

    int checks = 0;
    int errors = 0;
    bit started = 0;

    typedef struct {
        bit          v;
        int          simd;
        int          slot;
        logic [47:0] pc;
        bit          aok;
        int          aslot;
    } exp_t;
    exp_t exp_q[$];
    exp_t cur;

    // Reference model state, written from the requirements.
    bit          m_valid [NS][NW];
    bit          m_wait  [NS][NW];
    logic [47:0] m_pc    [NS][NW];
    int          m_last  [NS];
    int          m_cnt   [NS];
    int          m_ptr;

    int          gcount [NS][NW];
    logic [47:0] seen_pc_1_0;
    bit          last_aok;
    int          last_aslot;

    task automatic check(input string req, input string what, input longint act, input longint expv);
        checks++;
        if (act != expv) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h at %0t", req, what, act, expv, $time);
        end
    endtask

    function automatic int lowest_free(input int s);
        for (int i = 0; i < NW; i++) if (!m_valid[s][i]) return i;
        return -1;
    endfunction

    // Predictor: at mid-cycle compute what every output must show and queue it.
    always @(negedge clk) begin
        if (started) begin
            exp_t e;
            int s, lf;
            e.v = 0; e.simd = 0; e.slot = 0; e.pc = '0;
            s = m_ptr;
            if (rst_n && m_cnt[s] == 0 && !simd_busy[s]) begin
                for (int k = 1; k <= NW; k++) begin
                    int j;
                    j = (m_last[s] + k) % NW;
                    if (!e.v && m_valid[s][j] && !m_wait[s][j]) begin
                        e.v = 1; e.simd = s; e.slot = j; e.pc = m_pc[s][j];
                    end
                end
            end
            lf = lowest_free(int'(alloc_simd));
            e.aok   = alloc_valid && lf >= 0;
            e.aslot = (lf >= 0) ? lf : 0;
            cur = e;
            exp_q.push_back(e);
        end
    end

    // Monitor: pop the expected item and compare against the ports.
    always @(negedge clk) begin
        #0.5;
        if (started && exp_q.size() > 0) begin
            exp_t e;
            e = exp_q.pop_front();
            check("R1", "issue_valid", longint'(issue_valid), longint'(e.v));
            check("R1", "issue_simd", longint'(issue_simd), longint'(e.simd));
            check("R4", "issue_slot", longint'(issue_slot), longint'(e.slot));
            check("R5", "issue_pc", longint'(issue_pc), longint'(e.pc));
            check("R2", "alloc_ok", longint'(alloc_ok), longint'(e.aok));
            check("R2", "alloc_slot", longint'(alloc_slot), longint'(e.aslot));
            if (issue_valid) begin
                gcount[issue_simd][issue_slot]++;
                if (issue_simd == 1 && issue_slot == 0) seen_pc_1_0 = issue_pc;
            end
        end
    end

    // Model state update at each clock edge.
    always @(posedge clk) begin
        if (!rst_n) begin
            m_ptr = 0;
            for (int s = 0; s < NS; s++) begin
                m_last[s] = NW - 1; m_cnt[s] = 0;
                for (int i = 0; i < NW; i++) begin
                    m_valid[s][i] = 0; m_wait[s][i] = 0; m_pc[s][i] = '0;
                end
            end
        end else begin
            for (int s = 0; s < NS; s++) begin
                if (cur.v && cur.simd == s) begin m_cnt[s] = 3; m_last[s] = cur.slot; end
                else if (m_cnt[s] > 0) m_cnt[s]--;
            end
            m_ptr = (m_ptr + 1) % NS;
            for (int s = 0; s < NS; s++) begin
                for (int i = 0; i < NW; i++) begin
                    if (cur.aok && alloc_simd == s && cur.aslot == i) begin
                        m_valid[s][i] = 1; m_wait[s][i] = 0; m_pc[s][i] = alloc_pc;
                    end else begin
                        if (rel_valid && rel_simd == s && rel_slot == i) m_valid[s][i] = 0;
                        if (wset_valid && wset_simd == s && wset_slot == i)      m_wait[s][i] = 1;
                        else if (wclr_valid && wclr_simd == s && wclr_slot == i) m_wait[s][i] = 0;
                        if (pcw_valid && pcw_simd == s && pcw_slot == i) m_pc[s][i] = pcw_pc;
                    end
                end
            end
        end
        started = 1;
    end

    // Driver tasks: called just after a clock edge, hold the command one cycle.
    task automatic do_alloc(input int s, input logic [47:0] pc);
        alloc_valid = 1; alloc_simd = 2'(s); alloc_pc = pc;
        @(negedge clk); #1;
        last_aok = alloc_ok; last_aslot = int'(alloc_slot);
        @(posedge clk); #1;
        alloc_valid = 0;
    endtask

    task automatic do_release(input int s, input int w);
        rel_valid = 1; rel_simd = 2'(s); rel_slot = 4'(w);
        @(posedge clk); #1;
        rel_valid = 0;
    endtask

    task automatic do_wait(input int s, input int w, input bit set);
        if (set) begin wset_valid = 1; wset_simd = 2'(s); wset_slot = 4'(w); end
        else     begin wclr_valid = 1; wclr_simd = 2'(s); wclr_slot = 4'(w); end
        @(posedge clk); #1;
        wset_valid = 0; wclr_valid = 0;
    endtask

    task automatic do_pcw(input int s, input int w, input logic [47:0] pc);
        pcw_valid = 1; pcw_simd = 2'(s); pcw_slot = 4'(w); pcw_pc = pc;
        @(posedge clk); #1;
        pcw_valid = 0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic clear_counts();
        for (int s = 0; s < NS; s++) for (int i = 0; i < NW; i++) gcount[s][i] = 0;
    endtask

    function automatic int unit_total(input int s);
        int t;
        t = 0;
        for (int i = 0; i < NW; i++) t += gcount[s][i];
        return t;
    endfunction

    task automatic finish_run();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired, all requirements unchecked");
        finish_run();
    end

    initial begin
        clear_counts();
        repeat (3) @(posedge clk);
        #1;
        // Reset state: no grant, nothing allocated.
        check("R8", "reset issue_valid", longint'(issue_valid), 0);
        rst_n = 1;
        clear_counts();
        idle(8);
        check("R8", "no grants while empty", unit_total(0) + unit_total(1), 0);

        do_alloc(0, 48'h100); do_alloc(0, 48'h200); do_alloc(0, 48'h300);
        do_alloc(1, 48'h1000); do_alloc(1, 48'h1100);
        for (int i = 0; i < NW; i++) begin
            do_alloc(2, 48'h2000 + 48'(i * 4));
            check("R2", "fill slot index", longint'(last_aslot), longint'(i));
        end
        do_alloc(2, 48'h9999);
        check("R2", "full unit refuses", longint'(last_aok), 0);

        clear_counts();
        idle(24);
        for (int i = 0; i < 3; i++)
            check("R4", "fair share on unit 0", longint'(gcount[0][i] > 0), 1);
        check("R4", "unit 0 spread", longint'(gcount[0][0] - gcount[0][2] <= 1), 1);

        do_wait(0, 1, 1);
        clear_counts();
        idle(24);
        check("R6", "waiting slot skipped", longint'(gcount[0][1]), 0);
        check("R6", "others still issue", longint'(gcount[0][0] > 0), 1);
        do_wait(0, 1, 0);
        clear_counts();
        idle(24);
        check("R6", "completed slot issues again", longint'(gcount[0][1] > 0), 1);

        simd_busy = 4'b0010;
        clear_counts();
        idle(16);
        check("R3", "busy unit gets no grant", longint'(unit_total(1)), 0);
        simd_busy = 4'b0000;
        idle(4);

        do_pcw(1, 0, 48'hABCD_EF01_2345);
        idle(16);
        check("R5", "advanced pc seen", longint'(seen_pc_1_0), longint'(48'hABCD_EF01_2345));

        do_release(2, 4);
        do_alloc(2, 48'h7777);
        check("R7", "released slot reused", longint'(last_aslot), 4);
        check("R7", "reuse accepted", longint'(last_aok), 1);

        do_release(0, 0); do_release(0, 1); do_release(0, 2);
        clear_counts();
        idle(16);
        check("R8", "empty unit idle", longint'(unit_total(0)), 0);

        // Busy pattern toggling every cycle for mixed stimulus.
        for (int c = 0; c < 20; c++) begin
            simd_busy = 4'(c * 5);
            idle(1);
        end
        simd_busy = 0;
        idle(4);
        finish_run();
    end
endmodule